// File: doc/BRIEF.md
# I2C Configuration Register with Output Muxing

This block is a small I2C target holding one 5-bit configuration value. A controller addresses it with a fixed 7-bit address and then moves exactly one data byte: a write stores the low five bits when the write-protect input allows it and the upper three bits are clear, and a read returns the stored value with the upper three bits at zero. Bit 4 of the value feeds a single stand-alone output. Bits 3:0 form a nibble that can reach four muxed outputs.

An active-low override input and a select input pick one of four output behaviours. With both low, every output is zero. With override high and select low, both output groups show the register. With select high, the muxed outputs pass four external inputs through. The stand-alone output then shows the register bit when override is high. When override is low it holds the value it had in the cycle before select went high.

SCL and SDA arrive as oversampled lines and pass through a synchroniser. The block pulls SDA low only through an open-drain enable output.

Top module: `cfgmux_i2c`

## Requirements
- R1: While reset is high the register is cleared to 0x00 and the held stand-alone value is cleared to 0. After reset, a read returns 0x00.
- R2: Only the address byte {DEV_ADDR, R/W} is acknowledged, with SDA low in the ninth clock. After any other address the block keeps SDA released until the next START, and it changes nothing. A STOP releases SDA in the following cycle.
- R3: A write transaction (R/W = 0) with write-protect low and data bits 7:5 equal to 0 stores data bits 4:0 and acknowledges the data byte.
- R4: A write data byte received while write-protect is high is not acknowledged, and the register keeps its value.
- R5: A write data byte with any of bits 7:5 set is not acknowledged and is discarded.
- R6: A read transaction (R/W = 1) shifts out, MSB first, the byte {3'b000, register[4:0]}.
- R7: With override low and select low, mux_o is 4'b0000 and solo_o is 0.
- R8: With override high and select low, mux_o equals register[3:0] and solo_o equals register[4].
- R9: With select high, mux_o equals ext_i. With override high as well, solo_o equals register[4].
- R10: With override low and select high, solo_o holds the value solo_o had in the last cycle before select rose. This includes a select rise that lands in the same cycle as a register write.
- R11: Only the first data byte of a transaction is used. Any later bytes before STOP or START are neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wp_i | input | 1 | Write-protect, 1 blocks register updates |
| ovr_n_i | input | 1 | Active-low override |
| sel_i | input | 1 | Output source select |
| ext_i | input | 4 | External inputs for the muxed outputs |
| mux_o | output | 4 | Muxed outputs |
| solo_o | output | 1 | Stand-alone output |

## Verification
A register write commits on the system clock edge that follows the synchronised SCL fall after the eighth data bit. A select rise can land on that same edge, and it must capture the stand-alone output as it was before the commit. The bench sets up this case by counting the two synchroniser stages after it drives that SCL fall low. It then lowers override and raises select so that both changes are first sampled on the commit edge. The old register bit is 1 and the new one is 0, so the held value shows which side of the write the capture fell on. A later register view confirms that the write itself still took effect.

// File: rtl/cfgmux_pkg.sv
package cfgmux_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NIB_W  = 4;
    localparam int unsigned CFG_W  = NIB_W + 1;
    localparam int unsigned ADDR_W = BYTE_W - 1;
    localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [CFG_W-1:0]  cfg_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WR_DATA,
        PH_WR_ACK,
        PH_RD_DATA,
        PH_RD_ACK,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        OM_BLANK,
        OM_EXT_HELD,
        OM_REG,
        OM_EXT_REG
    } omode_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic omode_e pick_mode(input logic ovr_n, input logic sel);
        omode_e m;
        case ({ovr_n, sel})
            2'b00:   m = OM_BLANK;
            2'b01:   m = OM_EXT_HELD;
            2'b10:   m = OM_REG;
            default: m = OM_EXT_REG;
        endcase
        return m;
    endfunction

    function automatic logic upper_clear(input byte_t b);
        return b[BYTE_W-1:CFG_W] == '0;
    endfunction

    function automatic byte_t widen(input cfg_t c);
        return {{(BYTE_W-CFG_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import cfgmux_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff[0] <= 1'b1;
            sda_ff[0] <= 1'b1;
        end else begin
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_ff[g] <= 1'b1;
                sda_ff[g] <= 1'b1;
            end else begin
                scl_ff[g] <= scl_ff[g-1];
                sda_ff[g] <= sda_ff[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_ff[STAGES-1];
            sda_d <= sda_ff[STAGES-1];
        end
    end

    logic scl_s;
    logic sda_s;
    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
    import cfgmux_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h3A
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  logic    wp_i,
    input  cfg_t    cfg_q,
    output logic    sda_low,
    output logic    wr_en,
    output cfg_t    wr_data
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    byte_t            sh_q;
    logic             rw_q;
    logic             drv_q;
    byte_t            tx_w;
    logic             accept;
    logic             byte_done;

    assign tx_w      = widen(cfg_q);
    assign accept    = upper_clear(sh_q) & ~wp_i;
    assign byte_done = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            sh_q  <= '0;
            rw_q  <= 1'b0;
            drv_q <= 1'b0;
        end else if (ev.stop) begin
            ph_q  <= PH_IDLE;
            drv_q <= 1'b0;
        end else if (ev.start) begin
            ph_q  <= PH_ADDR;
            cnt_q <= '0;
            drv_q <= 1'b0;
        end else if (ev.scl_rise) begin
            case (ph_q)
                PH_ADDR, PH_WR_DATA: begin
                    sh_q  <= {sh_q[BYTE_W-2:0], ev.sda};
                    cnt_q <= cnt_q + 1'b1;
                end
                PH_RD_DATA: cnt_q <= cnt_q + 1'b1;
                default: ;
            endcase
        end else if (ev.scl_fall) begin
            case (ph_q)
                PH_ADDR: begin
                    if (byte_done) begin
                        if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                            ph_q  <= PH_ADDR_ACK;
                            drv_q <= 1'b1;
                            rw_q  <= sh_q[0];
                        end else begin
                            ph_q <= PH_SKIP;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    cnt_q <= '0;
                    if (rw_q) begin
                        ph_q  <= PH_RD_DATA;
                        sh_q  <= tx_w;
                        drv_q <= ~tx_w[BYTE_W-1];
                    end else begin
                        ph_q  <= PH_WR_DATA;
                        drv_q <= 1'b0;
                    end
                end
                PH_WR_DATA: begin
                    if (byte_done) begin
                        ph_q  <= PH_WR_ACK;
                        drv_q <= accept;
                    end
                end
                PH_WR_ACK: begin
                    ph_q  <= PH_SKIP;
                    drv_q <= 1'b0;
                end
                PH_RD_DATA: begin
                    if (byte_done) begin
                        ph_q  <= PH_RD_ACK;
                        drv_q <= 1'b0;
                    end else begin
                        sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                        drv_q <= ~sh_q[BYTE_W-2];
                    end
                end
                PH_RD_ACK: ph_q <= PH_SKIP;
                default: ;
            endcase
        end
    end

    assign sda_low = drv_q;
    assign wr_en   = (ph_q == PH_WR_DATA) & ev.scl_fall & byte_done & accept
                   & ~ev.stop & ~ev.start;
    assign wr_data = sh_q[CFG_W-1:0];

endmodule

// File: rtl/out_mux_stage.sv
module out_mux_stage
    import cfgmux_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ovr_n_i,
    input  logic sel_i,
    input  nib_t ext_i,
    input  cfg_t cfg_q,
    output nib_t mux_o,
    output logic solo_o
);

    omode_e mode;
    logic   held_q;

    assign mode = pick_mode(ovr_n_i, sel_i);

    // While select is low the holder follows the stand-alone output; from the
    // first cycle select is high it keeps the value of the cycle before.
    always_ff @(posedge clk) begin
        if (rst)         held_q <= 1'b0;
        else if (!sel_i) held_q <= solo_o;
    end

    for (genvar b = 0; b < NIB_W; b++) begin : g_bit
        always_comb begin
            case (mode)
                OM_BLANK:             mux_o[b] = 1'b0;
                OM_REG:               mux_o[b] = cfg_q[b];
                default:              mux_o[b] = ext_i[b];
            endcase
        end
    end

    always_comb begin
        case (mode)
            OM_BLANK:    solo_o = 1'b0;
            OM_EXT_HELD: solo_o = held_q;
            default:     solo_o = cfg_q[NIB_W];
        endcase
    end

endmodule

// File: rtl/cfgmux_i2c.sv
module cfgmux_i2c
    import cfgmux_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h3A,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_low_o,
    input  logic             wp_i,
    input  logic             ovr_n_i,
    input  logic             sel_i,
    input  logic [NIB_W-1:0] ext_i,
    output logic [NIB_W-1:0] mux_o,
    output logic             solo_o
);

    bus_ev_t ev;
    cfg_t    cfg_q;
    logic    wr_en;
    cfg_t    wr_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_cfg_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .wp_i    (wp_i),
        .cfg_q   (cfg_q),
        .sda_low (sda_low_o),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (wr_en) cfg_q <= wr_data;
    end

    out_mux_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .ovr_n_i (ovr_n_i),
        .sel_i   (sel_i),
        .ext_i   (ext_i),
        .cfg_q   (cfg_q),
        .mux_o   (mux_o),
        .solo_o  (solo_o)
    );

endmodule

// File: rtl/cfgmux_i2c_chk.sv
module cfgmux_i2c_chk
    import cfgmux_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    wp_i,
    input logic    ovr_n_i,
    input logic    sel_i,
    input logic    sda_low_o,
    input logic    solo_o,
    input nib_t    ext_i,
    input nib_t    mux_o,
    input cfg_t    cfg_q,
    input bus_ev_t ev
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cfg_q == '0));

    p_stop_release_r2: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_low_o);

    p_wp_guard_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q != $past(cfg_q)) |-> !$past(wp_i));

    p_blank_r7: assert property (@(posedge clk) disable iff (rst)
        (!ovr_n_i && !sel_i) |-> (mux_o == '0 && !solo_o));

    p_reg_view_r8: assert property (@(posedge clk) disable iff (rst)
        (ovr_n_i && !sel_i) |-> (mux_o == cfg_q[NIB_W-1:0] && solo_o == cfg_q[NIB_W]));

    p_ext_pass_r9: assert property (@(posedge clk) disable iff (rst)
        sel_i |-> (mux_o == ext_i));

    p_held_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (!ovr_n_i && sel_i && $past(!ovr_n_i && sel_i)) |-> $stable(solo_o));

endmodule

bind cfgmux_i2c cfgmux_i2c_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wp_i      (wp_i),
    .ovr_n_i   (ovr_n_i),
    .sel_i     (sel_i),
    .sda_low_o (sda_low_o),
    .solo_o    (solo_o),
    .ext_i     (ext_i),
    .mux_o     (mux_o),
    .cfg_q     (cfg_q),
    .ev        (ev)
);

// File: tb/cfgmux_i2c_tb_top.sv
`timescale 1ns/1ps
module cfgmux_i2c_tb_top;

    localparam logic [6:0] ADDR = 7'h3A;
    localparam int H = 20;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_low;
    logic       wp = 1'b0;
    logic       ovr_n = 1'b0;
    logic       sel = 1'b0;
    logic [3:0] ext = 4'h0;
    logic [3:0] mux;
    logic       solo;
    logic       sda_line;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    string q_req[$];
    int    q_exp[$];
    int    q_act[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_low;

    cfgmux_i2c #(.DEV_ADDR(ADDR)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_low_o(sda_low),
        .wp_i(wp), .ovr_n_i(ovr_n), .sel_i(sel), .ext_i(ext),
        .mux_o(mux), .solo_o(solo)
    );

    // driver side: push an expected item with the observed result
    task automatic chk(input string req, input int exp, input int act);
        q_req.push_back(req);
        q_exp.push_back(exp);
        q_act.push_back(act);
    endtask

    // monitor: pops and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            while (q_req.size() > 0) begin
                string r;
                int e;
                int a;
                r = q_req.pop_front();
                e = q_exp.pop_front();
                a = q_act.pop_front();
                n_chk++;
                if (a != e) begin
                    n_fail++;
                    $display("FAIL %s actual=0x%0h expected=0x%0h", r, a, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b0; tick(H);
        scl = 1'b0;   tick(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(H);
        scl = 1'b1; tick(H);
        repeat (H - 1) @(posedge clk);
        @(posedge clk); #1 scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(H);
        scl = 1'b1; tick(H / 2);
        b = sda_line;
        tick(H / 2);
        scl = 1'b0;
    endtask

    // collide=1 lowers override and raises select on the commit edge
    task automatic put_byte(input logic [7:0] v, input bit collide, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        if (collide) begin
            tick(2);
            ovr_n = 1'b0;
            sel = 1'b1;
        end
        get_bit(a);
        acked = (a == 1'b0);
    endtask

    task automatic get_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(1'b1);
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] d, input bit collide,
                          output bit ack_a, output bit ack_d);
        bus_start();
        put_byte({a, 1'b0}, 1'b0, ack_a);
        put_byte(d, collide, ack_d);
        bus_stop();
    endtask

    task automatic rd_txn(output bit ack_a, output logic [7:0] d);
        bus_start();
        put_byte({ADDR, 1'b1}, 1'b0, ack_a);
        get_byte(d);
        bus_stop();
    endtask

    task automatic view_reg(input string req, input logic [4:0] exp);
        ovr_n = 1'b1; sel = 1'b0; tick(2);
        chk(req, {27'd0, exp}, {27'd0, solo, mux});
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit aa;
        bit ad;
        logic [7:0] rd;

        tick(5);
        rst = 1'b0;
        tick(2);

        // R1 / R7: reset state with both controls low
        chk("R7 blank after reset", 0, {27'd0, solo, mux});
        view_reg("R1 register cleared", 5'h00);
        rd_txn(aa, rd);
        chk("R1 read after reset", 8'h00, rd);

        // R3 / R2: accepted write
        wr_txn(ADDR, 8'h15, 1'b0, aa, ad);
        chk("R2 address ack", 1, aa);
        chk("R3 data ack", 1, ad);
        view_reg("R8 register view 0x15", 5'h15);

        // R6: read back
        rd_txn(aa, rd);
        chk("R6 read ack", 1, aa);
        chk("R6 read byte", 8'h15, rd);

        // R4: write-protect
        wp = 1'b1;
        wr_txn(ADDR, 8'h0A, 1'b0, aa, ad);
        wp = 1'b0;
        chk("R4 nack under wp", 0, ad);
        view_reg("R4 register kept", 5'h15);

        // R5: upper bits set
        wr_txn(ADDR, 8'h2A, 1'b0, aa, ad);
        chk("R5 nack bit5", 0, ad);
        wr_txn(ADDR, 8'hE3, 1'b0, aa, ad);
        chk("R5 nack bits7:5", 0, ad);
        view_reg("R5 register kept", 5'h15);

        // R2: foreign address
        wr_txn(7'h3B, 8'h03, 1'b0, aa, ad);
        chk("R2 foreign address nack", 0, aa);
        chk("R2 foreign data nack", 0, ad);
        view_reg("R2 register kept", 5'h15);

        // R11: second byte in one transaction
        bus_start();
        put_byte({ADDR, 1'b0}, 1'b0, aa);
        put_byte(8'h0C, 1'b0, ad);
        chk("R11 first byte ack", 1, ad);
        put_byte(8'h11, 1'b0, ad);
        chk("R11 second byte nack", 0, ad);
        bus_stop();
        rd_txn(aa, rd);
        chk("R11 only first byte stored", 8'h0C, rd);

        // R9: external pass-through with register on solo_o
        ovr_n = 1'b1; sel = 1'b1; ext = 4'hA; tick(2);
        chk("R9 ext 0xA, solo reg", 5'h0A, {27'd0, solo, mux});
        ext = 4'h5; tick(1);
        chk("R9 ext 0x5", 5'h05, {27'd0, solo, mux});

        // R10: held value
        wr_txn(ADDR, 8'h1C, 1'b0, aa, ad);
        view_reg("R8 register view 0x1C", 5'h1C);
        ovr_n = 1'b0; sel = 1'b1; ext = 4'h3; tick(2);
        chk("R10 held 1 with ext 0x3", 5'h13, {27'd0, solo, mux});
        ext = 4'hF; tick(1);
        wr_txn(ADDR, 8'h00, 1'b0, aa, ad);
        chk("R10 held through write", 5'h1F, {27'd0, solo, mux});
        sel = 1'b0; tick(2);
        chk("R7 blank", 0, {27'd0, solo, mux});
        sel = 1'b1; tick(2);
        chk("R10 held 0 after blank", 5'h0F, {27'd0, solo, mux});

        // R10 collision: select rises on the commit edge of a write
        wr_txn(ADDR, 8'h10, 1'b0, aa, ad);
        ovr_n = 1'b1; sel = 1'b0; tick(2);
        wr_txn(ADDR, 8'h00, 1'b1, aa, ad);
        chk("R3 collision write ack", 1, ad);
        chk("R10 capture before commit", 1, {31'd0, solo});
        view_reg("R3 collision write stored", 5'h00);

        tick(10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule